// File: doc/BRIEF.md
# Nested interrupt priority arbiter

This block resolves which of a small set of interrupt sources should be serviced next, and whether that source may cut into the handler that is running now. Each source has an enable bit, a pending bit, an active bit and an 8-bit priority field. Only the top four bits of the priority field are stored. A key-guarded control word holds a 3-bit grouping code. The code divides those four bits into a group (preemption) part and a sub-priority part.

On every cycle the block selects the best eligible source, meaning enabled, pending and not already active. It compares that source's group value with the group value of the handler on top of its nesting stack and raises `preempt_req` when the core should be interrupted. The core answers with `ack` to start the offered handler and with `eoi` to end the running one. A stack of source numbers, as deep as the number of sources, restores the previous handler when a nested one ends.

A two-state machine tracks the nesting. The states are ST_IDLE (no handler running) and ST_RUN (at least one handler running). FIRST_TAKE goes from ST_IDLE to ST_RUN on an accepted request. NEST_TAKE stays in ST_RUN and pushes a deeper handler. UNWIND stays in ST_RUN and pops while more than one handler is stacked. LAST_POP goes from ST_RUN to ST_IDLE when the final handler ends.

Top module: `nest_prio_arbiter`

## Requirements
- R1: After reset all enable, pending and active bits and all priority fields are 0, the control word reads 0xFA050000, `preempt_req` and `run_valid` are 0 and `nest_depth` is 0.
- R2: A write to the control word (address 0x00) updates the grouping code in bits [10:8] only when bits [31:16] of the written data equal 0x05FA; otherwise nothing changes. A read of the control word returns 0xFA05 in [31:16], the grouping code in [10:8] and zero elsewhere.
- R3: The priority of source i is at address 0x40+4*i in bits [7:0]. Only bits [7:4] are stored; bits [3:0] and all bits above 7 read as zero.
- R4: Enable is set at 0x04 and cleared at 0x08, pending is set at 0x0C and cleared at 0x10, and the active bits read at 0x14, with bit i belonging to source i. In the set and clear views a 1 changes the bit and a 0 leaves it alone. Both views read back the current state.
- R5: A high `irq_in[i]` sets pending bit i at the next edge. This wins over a software clear or an acceptance of the same source in that cycle.
- R6: Among sources that are enabled, pending and not active, the one with the numerically lowest 4-bit priority is the candidate (group compared first, sub-priority second). On a full tie the lowest source number wins. `preempt_id` shows the candidate while `preempt_req` is high.
- R7: The number of sub-priority bits is code-3 for codes 0b011 to 0b111, and 0 for codes 0b000 to 0b010. The group value is the 4-bit priority shifted right by that count.
- R8: `preempt_req` is high when a candidate exists and either no handler runs or the candidate's group value is strictly lower than the running handler's group value. An equal group value never preempts.
- R9: `ack` with `preempt_req` high and `eoi` low makes the candidate the running handler at the next edge: its active bit sets, its pending bit clears and `nest_depth` rises by one.
- R10: `eoi` while a handler runs pops it at the next edge: its active bit clears, `nest_depth` falls by one and `run_id` returns to the handler below. `run_valid` falls when the depth reaches 0.
- R11: `eoi` with no handler running has no effect. `ack` has no effect while `preempt_req` is low or while `eoi` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_in | input | NSRC | Hardware request per source |
| ack | input | 1 | Core starts the offered handler |
| eoi | input | 1 | Core ends the running handler |
| preempt_req | output | 1 | Request to enter a handler |
| preempt_id | output | log2(NSRC) | Source offered |
| run_valid | output | 1 | A handler is running |
| run_id | output | log2(NSRC) | Source of the running handler |
| nest_depth | output | log2(NSRC+1) | Number of stacked handlers |

## Verification
The bound checker watches, on every cycle, that an offered source is enabled, pending and not active. It also checks that an accepted offer lands on top of the stack with the depth one higher, that an end-of-handler lowers the depth by one, that the number of active bits equals the depth, and that a control write without the key leaves the grouping unchanged. The bench's scenarios show the arbitration order and its tie-breaking, the equal-group rule, and how a grouping change alters preemption while a handler runs. They also show the register views, masking of the low priority bits, and that a hardware request wins over a software clear.

// File: rtl/nip_pkg.sv
package nip_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } nest_st_e;

    localparam logic [15:0] KEY_WRITE = 16'h05FA;
    localparam logic [15:0] KEY_SHOW  = 16'hFA05;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_ENSET = 'h04;
    localparam int OFS_ENCLR = 'h08;
    localparam int OFS_PDSET = 'h0C;
    localparam int OFS_PDCLR = 'h10;
    localparam int OFS_ACT   = 'h14;
    localparam int OFS_PRIO  = 'h40;

    localparam int PRIO_BITS = 4;

    // number of sub-priority bits for a grouping code
    function automatic logic [2:0] sub_width(input logic [2:0] code);
        if (code >= 3'd3) return code - 3'd3;
        return 3'd0;
    endfunction

    function automatic logic [PRIO_BITS-1:0] group_of(input logic [PRIO_BITS-1:0] p,
                                                      input logic [2:0] code);
        return p >> sub_width(code);
    endfunction

endpackage

// File: rtl/nip_regs.sv
module nip_regs
    import nip_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int AW   = 8,
    localparam int IDW = $clog2(NSRC)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [AW-1:0]                 reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic [NSRC-1:0]               irq_in,
    input  logic                          take,
    input  logic [IDW-1:0]                take_id,
    input  logic                          pop,
    input  logic [IDW-1:0]                pop_id,
    output logic [NSRC-1:0]               en_q,
    output logic [NSRC-1:0]               pend_q,
    output logic [NSRC-1:0]               act_q,
    output logic [NSRC-1:0][PRIO_BITS-1:0] prio_q,
    output logic [2:0]                    grp_q
);

    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] take_mask;
    logic [NSRC-1:0] pop_mask;
    logic            hit_ctrl, hit_enset, hit_enclr, hit_pdset, hit_pdclr;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata[15:11];

    assign wmask     = reg_wdata[NSRC-1:0];
    assign take_mask = take ? (NSRC'(1) << take_id) : '0;
    assign pop_mask  = pop  ? (NSRC'(1) << pop_id)  : '0;

    assign hit_ctrl  = reg_wr && (reg_addr == AW'(OFS_CTRL));
    assign hit_enset = reg_wr && (reg_addr == AW'(OFS_ENSET));
    assign hit_enclr = reg_wr && (reg_addr == AW'(OFS_ENCLR));
    assign hit_pdset = reg_wr && (reg_addr == AW'(OFS_PDSET));
    assign hit_pdclr = reg_wr && (reg_addr == AW'(OFS_PDCLR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp_q <= 3'd0;
        end else if (hit_ctrl && reg_wdata[31:16] == KEY_WRITE) begin
            grp_q <= reg_wdata[10:8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (hit_enset) en_q <= en_q | wmask;
            else if (hit_enclr) en_q <= en_q & ~wmask;
            pend_q <= (pend_q & ~(hit_pdclr ? wmask : '0) & ~take_mask)
                      | (hit_pdset ? wmask : '0) | irq_in;
            act_q  <= (act_q | take_mask) & ~pop_mask;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_prio
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prio_q[i] <= '0;
            end else if (reg_wr && reg_addr == AW'(OFS_PRIO + 4 * i)) begin
                prio_q[i] <= reg_wdata[7:4];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(OFS_CTRL)) begin
            reg_rdata = {KEY_SHOW, 5'd0, grp_q, 8'd0};
        end else if (reg_addr == AW'(OFS_ENSET) || reg_addr == AW'(OFS_ENCLR)) begin
            reg_rdata = 32'(en_q);
        end else if (reg_addr == AW'(OFS_PDSET) || reg_addr == AW'(OFS_PDCLR)) begin
            reg_rdata = 32'(pend_q);
        end else if (reg_addr == AW'(OFS_ACT)) begin
            reg_rdata = 32'(act_q);
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (reg_addr == AW'(OFS_PRIO + 4 * i)) reg_rdata = {24'd0, prio_q[i], 4'd0};
            end
        end
    end

endmodule

// File: rtl/nip_resolve.sv
module nip_resolve
    import nip_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]                elig,
    input  logic [NSRC-1:0][PRIO_BITS-1:0] prio,
    output logic                           cand_valid,
    output logic [IDW-1:0]                 cand_id,
    output logic [PRIO_BITS-1:0]           cand_prio
);

    // strict compare keeps the lowest index on a full tie
    always_comb begin
        cand_valid = 1'b0;
        cand_id    = '0;
        cand_prio  = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!cand_valid || prio[i] < cand_prio)) begin
                cand_valid = 1'b1;
                cand_id    = IDW'(i);
                cand_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/nip_stack.sv
module nip_stack
    import nip_pkg::*;
#(
    parameter int NSRC = 8,
    localparam int IDW = $clog2(NSRC),
    localparam int DW  = $clog2(NSRC + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [IDW-1:0] push_id,
    input  logic           pop,
    output logic           top_valid,
    output logic [IDW-1:0] top_id,
    output logic [DW-1:0]  depth
);

    nest_st_e       st_q, st_d;
    logic [DW-1:0]  depth_q, depth_d;
    logic [IDW-1:0] stk_q [NSRC];
    logic           room;

    assign room = depth_q < DW'(NSRC);

    // next state: FIRST_TAKE, NEST_TAKE, UNWIND, LAST_POP
    always_comb begin
        st_d    = st_q;
        depth_d = depth_q;
        unique case (st_q)
            ST_IDLE: begin
                if (push) begin
                    st_d    = ST_RUN;
                    depth_d = DW'(1);
                end
            end
            ST_RUN: begin
                if (pop) begin
                    depth_d = depth_q - DW'(1);
                    if (depth_q == DW'(1)) st_d = ST_IDLE;
                end else if (push && room) begin
                    depth_d = depth_q + DW'(1);
                end
            end
            default: begin
                st_d    = ST_IDLE;
                depth_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            depth_q <= '0;
        end else begin
            st_q    <= st_d;
            depth_q <= depth_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) stk_q[i] <= '0;
        end else if (push && !pop && room) begin
            stk_q[IDW'(depth_q)] <= push_id;
        end
    end

    always_comb begin
        top_valid = (st_q == ST_RUN);
        top_id    = top_valid ? stk_q[IDW'(depth_q - DW'(1))] : '0;
        depth     = depth_q;
    end

endmodule

// File: rtl/nest_prio_arbiter.sv
module nest_prio_arbiter
    import nip_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int AW   = 8,
    localparam int IDW = $clog2(NSRC),
    localparam int DW  = $clog2(NSRC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NSRC-1:0] irq_in,
    input  logic            ack,
    input  logic            eoi,
    output logic            preempt_req,
    output logic [IDW-1:0]  preempt_id,
    output logic            run_valid,
    output logic [IDW-1:0]  run_id,
    output logic [DW-1:0]   nest_depth
);

    logic [NSRC-1:0]                en_q, pend_q, act_q;
    logic [NSRC-1:0][PRIO_BITS-1:0] prio_q;
    logic [2:0]                     grp_q;
    logic                           cand_valid;
    logic [IDW-1:0]                 cand_id;
    logic [PRIO_BITS-1:0]           cand_prio;
    logic                           top_valid;
    logic [IDW-1:0]                 top_id;
    logic [DW-1:0]                  depth;
    logic [PRIO_BITS-1:0]           cand_grp, run_grp;
    logic                           take, pop;

    nip_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_in   (irq_in),
        .take     (take),
        .take_id  (cand_id),
        .pop      (pop),
        .pop_id   (top_id),
        .en_q     (en_q),
        .pend_q   (pend_q),
        .act_q    (act_q),
        .prio_q   (prio_q),
        .grp_q    (grp_q)
    );

    nip_resolve #(.NSRC(NSRC)) u_resolve (
        .elig      (en_q & pend_q & ~act_q),
        .prio      (prio_q),
        .cand_valid(cand_valid),
        .cand_id   (cand_id),
        .cand_prio (cand_prio)
    );

    nip_stack #(.NSRC(NSRC)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .push_id  (cand_id),
        .pop      (pop),
        .top_valid(top_valid),
        .top_id   (top_id),
        .depth    (depth)
    );

    // group values follow the live grouping code
    assign cand_grp = group_of(cand_prio, grp_q);
    assign run_grp  = group_of(prio_q[top_id], grp_q);

    assign preempt_req = cand_valid && (!top_valid || cand_grp < run_grp);
    assign preempt_id  = cand_id;
    assign take        = ack && !eoi && preempt_req;
    assign pop         = eoi && top_valid;

    assign run_valid  = top_valid;
    assign run_id     = top_id;
    assign nest_depth = depth;

endmodule

// File: rtl/nip_checker.sv
module nip_checker #(
    parameter int NSRC = 8,
    parameter int AW   = 8,
    localparam int IDW = $clog2(NSRC),
    localparam int DW  = $clog2(NSRC + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [AW-1:0]   reg_addr,
    input logic [15:0]     wkey,
    input logic            ack,
    input logic            eoi,
    input logic            preempt_req,
    input logic [IDW-1:0]  preempt_id,
    input logic            run_valid,
    input logic [IDW-1:0]  run_id,
    input logic [DW-1:0]   nest_depth,
    input logic [NSRC-1:0] en,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] act,
    input logic [2:0]      grp
);

    a_r2_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && wkey != 16'h05FA) |=> $stable(grp));

    a_r6_offer_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_req |-> (en[preempt_id] && pend[preempt_id] && !act[preempt_id]));

    a_r9_take_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi && preempt_req) |=>
            (run_valid && run_id == $past(preempt_id)
             && nest_depth == $past(nest_depth) + DW'(1)));

    a_r10_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && run_valid) |=> nest_depth == $past(nest_depth) - DW'(1));

    a_r10_active_matches_depth: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act) == int'(nest_depth));

    a_r10_state_matches_depth: assert property (@(posedge clk) disable iff (!rst_n)
        run_valid == (nest_depth != '0));

    a_r11_idle_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !run_valid) |=> nest_depth == '0);

endmodule

bind nest_prio_arbiter nip_checker #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wkey       (reg_wdata[31:16]),
    .ack        (ack),
    .eoi        (eoi),
    .preempt_req(preempt_req),
    .preempt_id (preempt_id),
    .run_valid  (run_valid),
    .run_id     (run_id),
    .nest_depth (nest_depth),
    .en         (en_q),
    .pend       (pend_q),
    .act        (act_q),
    .grp        (grp_q)
);

// File: tb/nest_prio_arbiter_test.sv
`timescale 1ns/1ps
module nest_prio_arbiter_test;

    localparam int NSRC = 8;
    localparam int AW   = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] irq_in = '0;
    logic            ack = 1'b0;
    logic            eoi = 1'b0;
    logic            preempt_req;
    logic [2:0]      preempt_id;
    logic            run_valid;
    logic [2:0]      run_id;
    logic [3:0]      nest_depth;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nest_prio_arbiter #(.NSRC(NSRC), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .ack(ack), .eoi(eoi), .preempt_req(preempt_req), .preempt_id(preempt_id),
        .run_valid(run_valid), .run_id(run_id), .nest_depth(nest_depth)
    );

    // {enable[7:0], pending[7:0], expect_req, expect_id[2:0]}
    // priorities nibbles: s0=5 s1=3 s2=3 s3=8 s4=1 s5=7 s6=F s7=2
    localparam logic [19:0] VEC [0:9] = '{
        {8'hFF, 8'h00, 1'b0, 3'd0},
        {8'hFF, 8'h01, 1'b1, 3'd0},
        {8'hFF, 8'h06, 1'b1, 3'd1},
        {8'hFF, 8'hFF, 1'b1, 3'd4},
        {8'hEF, 8'hFF, 1'b1, 3'd7},
        {8'h6F, 8'hFF, 1'b1, 3'd1},
        {8'hFF, 8'h48, 1'b1, 3'd3},
        {8'h00, 8'hFF, 1'b0, 3'd0},
        {8'hFF, 8'h60, 1'b1, 3'd5},
        {8'h0F, 8'hF0, 1'b0, 3'd0}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_irq(input logic [7:0] m);
        @(negedge clk); irq_in = m;
        @(negedge clk); irq_in = '0;
        #1;
    endtask

    task automatic pulse_core(input logic a, input logic e);
        @(negedge clk); ack = a; eoi = e;
        @(negedge clk); ack = 1'b0; eoi = 1'b0;
        #1;
    endtask

    task automatic check_offer(input string tag, input logic req, input logic [2:0] id);
        check({tag, " req"}, 32'(preempt_req), 32'(req));
        if (req) check({tag, " id"}, 32'(preempt_id), 32'(id));
    endtask

    task automatic check_run(input string tag, input logic v, input logic [2:0] id, input int d);
        check({tag, " run_valid"}, 32'(run_valid), 32'(v));
        if (v) check({tag, " run_id"}, 32'(run_id), 32'(id));
        check({tag, " depth"}, 32'(nest_depth), 32'(d));
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0] nib [8];
        nib = '{8'h50, 8'h30, 8'h30, 8'h80, 8'h10, 8'h70, 8'hF0, 8'h20};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        rd(8'h00, r); check("R1 ctrl", r, 32'hFA050000);
        rd(8'h04, r); check("R1 enable", r, 0);
        rd(8'h0C, r); check("R1 pending", r, 0);
        rd(8'h14, r); check("R1 active", r, 0);
        rd(8'h40, r); check("R1 prio0", r, 0);
        check("R1 preempt_req", 32'(preempt_req), 0);
        check_run("R1", 1'b0, 3'd0, 0);

        // R3 priority field masking
        wr(8'h40, 32'h0000005A); rd(8'h40, r); check("R3 low bits", r, 32'h50);
        wr(8'h40, 32'hFFFFFF3C); rd(8'h40, r); check("R3 high bits", r, 32'h30);

        // R4 set and clear views
        wr(8'h04, 32'h0F); rd(8'h04, r); check("R4 enset read", r, 32'h0F);
        rd(8'h08, r); check("R4 enclr read", r, 32'h0F);
        wr(8'h08, 32'h03); rd(8'h04, r); check("R4 clear ones", r, 32'h0C);
        wr(8'h04, 32'h00); rd(8'h04, r); check("R4 zero write", r, 32'h0C);
        wr(8'h0C, 32'h02); rd(8'h10, r); check("R4 pend set", r, 32'h02);

        // R5 hardware set beats software clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h10; reg_wdata = 32'h02; irq_in = 8'h02;
        @(negedge clk);
        reg_wr = 1'b0; irq_in = '0;
        rd(8'h0C, r); check("R5 irq over clear", r, 32'h02);
        wr(8'h10, 32'h02); rd(8'h0C, r); check("R4 pend cleared", r, 32'h00);

        for (int i = 0; i < NSRC; i++) wr(8'(8'h40 + 4 * i), 32'(nib[i]));

        // R6 arbitration table, no handler running
        for (int v = 0; v < 10; v++) begin
            wr(8'h08, 32'hFF); wr(8'h04, 32'(VEC[v][19:12]));
            wr(8'h10, 32'hFF); wr(8'h0C, 32'(VEC[v][11:4]));
            #1;
            check_offer($sformatf("R6 vec%0d", v), VEC[v][3], VEC[v][2:0]);
        end

        wr(8'h10, 32'hFF);
        wr(8'h04, 32'hFF);

        // R2 keyed write, code 0b101: group = prio >> 2
        wr(8'h00, 32'h05FA0500); rd(8'h00, r); check("R2 keyed write", r, 32'hFA050500);

        pulse_irq(8'h08);
        check_offer("R5 R8 irq offers s3", 1'b1, 3'd3);
        pulse_core(1'b1, 1'b0);
        check_run("R9 first take", 1'b1, 3'd3, 1);
        rd(8'h0C, r); check("R9 pending cleared", r, 0);
        rd(8'h14, r); check("R9 active set", r, 32'h08);

        pulse_irq(8'h20);
        check_offer("R8 lower group preempts", 1'b1, 3'd5);
        pulse_core(1'b1, 1'b0);
        check_run("R9 nested take", 1'b1, 3'd5, 2);

        pulse_irq(8'h01);
        check_offer("R8 equal group waits", 1'b0, 3'd0);
        pulse_core(1'b1, 1'b0);
        check_run("R11 ack without req", 1'b1, 3'd5, 2);

        pulse_irq(8'h10);
        check_offer("R6 R8 best pending s4", 1'b1, 3'd4);
        pulse_core(1'b0, 1'b1);
        check_run("R10 unwind", 1'b1, 3'd3, 1);
        rd(8'h14, r); check("R10 active after pop", r, 32'h08);
        check_offer("R8 after unwind", 1'b1, 3'd4);

        pulse_core(1'b1, 1'b0);
        check_run("R9 take s4", 1'b1, 3'd4, 2);
        check_offer("R8 s0 blocked by s4", 1'b0, 3'd0);
        pulse_core(1'b0, 1'b1);
        check_run("R10 back to s3", 1'b1, 3'd3, 1);
        check_offer("R8 s0 preempts s3", 1'b1, 3'd0);
        pulse_core(1'b0, 1'b1);
        check_run("R10 last pop", 1'b0, 3'd0, 0);

        pulse_core(1'b0, 1'b1);
        check_run("R11 eoi when idle", 1'b0, 3'd0, 0);
        pulse_core(1'b1, 1'b1);
        check_run("R11 ack with eoi", 1'b0, 3'd0, 0);
        rd(8'h0C, r); check("R11 pending kept", r, 32'h01);

        pulse_core(1'b1, 1'b0);
        check_run("R9 take s0", 1'b1, 3'd0, 1);
        rd(8'h14, r); check("R9 active s0", r, 32'h01);

        // R7 grouping change while s0 (prio 5) runs, s4 (prio 1) pending
        wr(8'h00, 32'h05FA0700);
        pulse_irq(8'h10);
        check_offer("R7 no group bits", 1'b0, 3'd0);
        wr(8'h00, 32'h12340300); rd(8'h00, r); check("R2 bad key", r, 32'hFA050700);
        #1;
        check_offer("R2 bad key no effect", 1'b0, 3'd0);
        wr(8'h00, 32'h05FA0300);
        #1;
        check_offer("R7 four group bits", 1'b1, 3'd4);
        wr(8'h00, 32'h05FA0100);
        #1;
        check_offer("R7 low code acts as four", 1'b1, 3'd4);
        wr(8'h00, 32'h05FA0600);
        #1;
        check_offer("R7 one group bit", 1'b0, 3'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule